// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block decides what each of six 16-bit counter channels sees on its clock and gate inputs. The channels sit in two counter blocks of three. For every channel the router keeps a 5-bit clock source code and a 5-bit gate source code. It drives one clock multiplexer and one gate multiplexer per channel from those codes. The sources are the channel's dedicated pins, a set of decade reference clocks that the block makes itself, constant levels, and the output of the neighbouring counter.

Software changes one channel at a time with a single byte written through either the clock-select strobe or the gate-select strobe. Bit 5 of the byte picks the counter block and bits 4:3 pick the channel inside it. The source code is split across the byte: code bits 2:0 sit in byte bits 2:0 and code bits 4:3 sit in byte bits 7:6.

An enhanced-mode input widens the accepted code range from 0..7 to 0..31. The reference clocks come from a free-running divider chain running off the 20 MHz system clock. They are produced as single-cycle enable pulses, so no derived clock net is created. A counter that uses a routed clock counts on the cycles where that clock output is high.

Top module: `ctr_route_top`

## Requirements
- R1: After reset, every channel's clock output follows its dedicated clock pin (code 0) and every gate output is logic 1 (code 0).
- R2: A byte written with a select strobe updates only the channel named by byte bit 5 (block) and bits 4:3 (channel, global index = block*3 + channel). The source code is {byte[7:6], byte[2:0]}. The new routing is visible in the cycle after the strobe edge.
- R3: A write whose channel field is 3 changes no channel's routing.
- R4: Clock codes 1 to 5 route enable pulses of period 2, 20, 200, 2000 and 20000 system cycles (10 MHz, 1 MHz, 100 kHz, 10 kHz, 1 kHz from 20 MHz). Each pulse is one cycle wide.
- R5: Clock code 6 routes the counter output of the preceding channel; channel 0 takes the output of the last channel.
- R6: Gate code 0 is logic 1, gate code 1 routes the channel's gate pin, and gate code 2 routes the preceding channel's counter output.
- R7: With enhanced mode off, a write carrying a source code above 7 is ignored and leaves the stored selection unchanged.
- R8: With enhanced mode on, codes up to 31 are stored. Clock code 11 routes the full 20 MHz rate, which is high on every cycle.
- R9: Unassigned codes route logic 0. These are clock code 7, clock codes 8..31 other than 11, and gate codes 3..31. A stored code above 7 also routes logic 0 whenever enhanced mode is off.
- R10: The clock-select and gate-select registers are independent: a strobe on one never changes the other. Both strobes together apply the same byte to both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enh_mode | input | 1 | Enhanced mode: accept and decode source codes above 7 |
| clk_sel_wr | input | 1 | Strobe: write sel_byte into a clock selection |
| gate_sel_wr | input | 1 | Strobe: write sel_byte into a gate selection |
| sel_byte | input | 8 | Packed block, channel and source code |
| ext_clk_in | input | 6 | Dedicated clock pin of each channel |
| gate_pin_in | input | 6 | Dedicated gate pin of each channel |
| ctr_out_in | input | 6 | Output of each counter, for chaining |
| ch_clk_out | output | 6 | Routed clock enable of each channel |
| ch_gate_out | output | 6 | Routed gate level of each channel |

## Verification
The hardest state to reach is a channel that holds a code above 7 while enhanced mode is off. Getting there takes a write made with enhanced mode on, followed by a later change of the mode input. The random stimulus picks the mode again for every write and never clears stored codes, so such channels build up and are checked after each following write. The slowest reference clock appears only once every 20000 cycles. Its rate is checked by routing all five reference codes to five channels at once and counting pulses over one exact 20000-cycle window.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;

   localparam int SRC_W = 5;
   typedef logic [SRC_W-1:0] src_code_t;

   // clock source codes
   localparam src_code_t CK_PIN   = 5'd0;
   localparam src_code_t CK_CHAIN = 5'd6;
   localparam src_code_t CK_FAST  = 5'd11;
   // gate source codes
   localparam src_code_t GT_HIGH  = 5'd0;
   localparam src_code_t GT_PIN   = 5'd1;
   localparam src_code_t GT_CHAIN = 5'd2;
   // highest code accepted without enhanced mode
   localparam src_code_t BASE_MAX = 5'd7;

   function automatic src_code_t byte_code(input logic [7:0] b);
      return {b[7:6], b[2:0]};
   endfunction

endpackage

// File: rtl/ctr_ref_divider.sv
module ctr_ref_divider #(
   parameter int FIRST_DIV = 2,
   parameter int NUM_REF   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [NUM_REF-1:0] ref_pulse
);
   localparam int PRE_W = (FIRST_DIV > 1) ? $clog2(FIRST_DIV) : 1;

   if (FIRST_DIV < 2) begin : g_bad_div
      $error("FIRST_DIV must be at least 2");
   end
   if (NUM_REF < 1) begin : g_bad_ref
      $error("NUM_REF must be at least 1");
   end

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                                 pre_q <= '0;
      else if (pre_q == PRE_W'(FIRST_DIV - 1))    pre_q <= '0;
      else                                        pre_q <= pre_q + 1'b1;
   end

   assign ref_pulse[0] = (pre_q == PRE_W'(FIRST_DIV - 1));

   a_r4_first_single: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pulse[0] |=> !ref_pulse[0]);

   for (genvar k = 1; k < NUM_REF; k++) begin : g_decade
      logic [3:0] dec_q;
      always_ff @(posedge clk) begin
         if (!rst_n)              dec_q <= 4'd0;
         else if (ref_pulse[k-1]) dec_q <= (dec_q == 4'd9) ? 4'd0 : dec_q + 4'd1;
      end
      assign ref_pulse[k] = ref_pulse[k-1] && (dec_q == 4'd9);

      // R4: a slower pulse is one cycle wide and coincides with the faster one
      a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         ref_pulse[k] |=> !ref_pulse[k]);
      a_r4_nested: assert property (@(posedge clk) disable iff (!rst_n)
         ref_pulse[k] |-> ref_pulse[k-1]);
   end

endmodule

// File: rtl/ctr_sel_bank.sv
module ctr_sel_bank
   import ctr_route_pkg::*;
#(
   parameter int NUM_BLK    = 2,
   parameter int CH_PER_BLK = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      enh_mode,
   input  logic      wr_en,
   input  logic [7:0] wr_byte,
   output src_code_t sel_q [NUM_BLK*CH_PER_BLK]
);
   localparam int NCH = NUM_BLK * CH_PER_BLK;

   src_code_t wr_code;
   logic      code_ok;
   logic      addr_ok;

   assign wr_code = byte_code(wr_byte);
   assign code_ok = enh_mode || (wr_code <= BASE_MAX);
   assign addr_ok = (32'(wr_byte[4:3]) < CH_PER_BLK) && (32'(wr_byte[5]) < NUM_BLK);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int BLK = i / CH_PER_BLK;
      localparam int CH  = i % CH_PER_BLK;
      logic hit;

      assign hit = wr_en && code_ok && addr_ok &&
                   (32'(wr_byte[5]) == BLK) && (32'(wr_byte[4:3]) == CH);

      always_ff @(posedge clk) begin
         if (!rst_n)   sel_q[i] <= '0;
         else if (hit) sel_q[i] <= wr_code;
      end

      // R2: a channel not named by the byte keeps its selection
      a_r2_only_addressed: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && 32'(wr_byte[5]) == BLK && 32'(wr_byte[4:3]) == CH) |=> $stable(sel_q[i]));
      // R7: wide codes outside enhanced mode are dropped
      a_r7_wide_dropped: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !enh_mode && wr_byte[7:6] != 2'b00) |=> $stable(sel_q[i]));
   end

endmodule

// File: rtl/ctr_src_mux.sv
module ctr_src_mux
   import ctr_route_pkg::*;
#(
   parameter int NUM_REF = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enh_mode,
   input  src_code_t          clk_sel,
   input  src_code_t          gate_sel,
   input  logic [NUM_REF-1:0] ref_pulse,
   input  logic               pin_clk,
   input  logic               pin_gate,
   input  logic               chain_in,
   output logic               clk_o,
   output logic               gate_o
);
   always_comb begin
      clk_o = 1'b0;
      if (clk_sel == CK_PIN)                 clk_o = pin_clk;
      else if (clk_sel == CK_CHAIN)          clk_o = chain_in;
      else if (clk_sel == CK_FAST)           clk_o = enh_mode;
      for (int k = 0; k < NUM_REF; k++) begin
         if (clk_sel == SRC_W'(k + 1))       clk_o = ref_pulse[k];
      end
   end

   always_comb begin
      unique case (gate_sel)
         GT_HIGH:  gate_o = 1'b1;
         GT_PIN:   gate_o = pin_gate;
         GT_CHAIN: gate_o = chain_in;
         default:  gate_o = 1'b0;
      endcase
   end

   // R9: wide codes route logic 0 with enhanced mode off
   a_r9_wide_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!enh_mode && clk_sel > BASE_MAX) |-> !clk_o);
   a_r9_wide_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_sel > BASE_MAX) |-> !gate_o);
   // R6: gate code 0 is constant high
   a_r6_gate_high: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_sel == GT_HIGH) |-> gate_o);

endmodule

// File: rtl/ctr_route_top.sv
module ctr_route_top
   import ctr_route_pkg::*;
#(
   parameter int NUM_BLK    = 2,
   parameter int CH_PER_BLK = 3,
   parameter int FIRST_DIV  = 2,
   parameter int NUM_REF    = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            enh_mode,
   input  logic                            clk_sel_wr,
   input  logic                            gate_sel_wr,
   input  logic [7:0]                      sel_byte,
   input  logic [NUM_BLK*CH_PER_BLK-1:0]   ext_clk_in,
   input  logic [NUM_BLK*CH_PER_BLK-1:0]   gate_pin_in,
   input  logic [NUM_BLK*CH_PER_BLK-1:0]   ctr_out_in,
   output logic [NUM_BLK*CH_PER_BLK-1:0]   ch_clk_out,
   output logic [NUM_BLK*CH_PER_BLK-1:0]   ch_gate_out
);
   localparam int NCH = NUM_BLK * CH_PER_BLK;

   if (NUM_BLK < 1 || NUM_BLK > 2) begin : g_bad_blk
      $error("NUM_BLK must fit the one-bit block field");
   end
   if (CH_PER_BLK < 1 || CH_PER_BLK > 3) begin : g_bad_ch
      $error("CH_PER_BLK must fit the two-bit channel field");
   end
   if (NUM_REF > 5) begin : g_bad_nref
      $error("reference codes would overlap the chain code");
   end

   logic [NUM_REF-1:0] ref_pulse;
   src_code_t          clk_sel  [NCH];
   src_code_t          gate_sel [NCH];

   ctr_ref_divider #(.FIRST_DIV(FIRST_DIV), .NUM_REF(NUM_REF)) u_div (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse));

   ctr_sel_bank #(.NUM_BLK(NUM_BLK), .CH_PER_BLK(CH_PER_BLK)) u_clk_bank (
      .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode),
      .wr_en(clk_sel_wr), .wr_byte(sel_byte), .sel_q(clk_sel));

   ctr_sel_bank #(.NUM_BLK(NUM_BLK), .CH_PER_BLK(CH_PER_BLK)) u_gate_bank (
      .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode),
      .wr_en(gate_sel_wr), .wr_byte(sel_byte), .sel_q(gate_sel));

   for (genvar i = 0; i < NCH; i++) begin : g_route
      localparam int PREV = (i == 0) ? NCH - 1 : i - 1;
      ctr_src_mux #(.NUM_REF(NUM_REF)) u_mux (
         .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode),
         .clk_sel(clk_sel[i]), .gate_sel(gate_sel[i]),
         .ref_pulse(ref_pulse),
         .pin_clk(ext_clk_in[i]), .pin_gate(gate_pin_in[i]),
         .chain_in(ctr_out_in[PREV]),
         .clk_o(ch_clk_out[i]), .gate_o(ch_gate_out[i]));
   end

   // R10: a gate-only write leaves every clock selection in place
   for (genvar i = 0; i < NCH; i++) begin : g_chk
      a_r10_gate_write_keeps_clk: assert property (@(posedge clk) disable iff (!rst_n)
         (gate_sel_wr && !clk_sel_wr) |=> $stable(clk_sel[i]));
   end

endmodule

// File: tb/ctr_route_top_test.sv
module ctr_route_top_test;
   localparam int NCH = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           enh_mode = 1'b0;
   logic           clk_sel_wr = 1'b0;
   logic           gate_sel_wr = 1'b0;
   logic [7:0]     sel_byte = 8'h00;
   logic [NCH-1:0] ext_clk_in = '0;
   logic [NCH-1:0] gate_pin_in = '0;
   logic [NCH-1:0] ctr_out_in = '0;
   logic [NCH-1:0] ch_clk_out;
   logic [NCH-1:0] ch_gate_out;

   int n_checks = 0;
   int n_fails  = 0;
   int m_clk  [NCH];
   int m_gate [NCH];

   always #5 clk = ~clk;

   ctr_route_top uut (
      .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode),
      .clk_sel_wr(clk_sel_wr), .gate_sel_wr(gate_sel_wr), .sel_byte(sel_byte),
      .ext_clk_in(ext_clk_in), .gate_pin_in(gate_pin_in), .ctr_out_in(ctr_out_in),
      .ch_clk_out(ch_clk_out), .ch_gate_out(ch_gate_out));

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
   end

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int prev(input int i);
      return (i == 0) ? NCH - 1 : i - 1;
   endfunction

   // -1 means a reference pulse, checked only by counting
   function automatic int exp_clk(input int i);
      int c = m_clk[i];
      if (c == 0) return int'(ext_clk_in[i]);
      if (c >= 1 && c <= 5) return -1;
      if (c == 6) return int'(ctr_out_in[prev(i)]);
      if (c == 11) return enh_mode ? 1 : 0;
      return 0;
   endfunction

   function automatic int exp_gate(input int i);
      int c = m_gate[i];
      if (c == 0) return 1;
      if (c == 1) return int'(gate_pin_in[i]);
      if (c == 2) return int'(ctr_out_in[prev(i)]);
      return 0;
   endfunction

   function automatic void model_write(input logic [7:0] b, input logic wc,
                                       input logic wg, input logic enh);
      int ch  = int'(b[4:3]);
      int idx = int'(b[5]) * 3 + ch;
      int src = int'({b[7:6], b[2:0]});
      if (ch < 3 && (enh || src <= 7)) begin
         if (wc) m_clk[idx]  = src;
         if (wg) m_gate[idx] = src;
      end
   endfunction

   task automatic write_sel(input logic [7:0] b, input logic wc, input logic wg,
                            input logic enh);
      @(negedge clk);
      sel_byte = b; clk_sel_wr = wc; gate_sel_wr = wg; enh_mode = enh;
      model_write(b, wc, wg, enh);
      @(negedge clk);
      clk_sel_wr = 1'b0; gate_sel_wr = 1'b0;
   endtask

   task automatic check_all(input string req);
      #1;
      for (int i = 0; i < NCH; i++) begin
         int e = exp_clk(i);
         if (e >= 0) chk(req, int'(ch_clk_out[i]), e);
         chk(req, int'(ch_gate_out[i]), exp_gate(i));
      end
   endtask

   task automatic shake_inputs();
      ext_clk_in  = NCH'($urandom);
      gate_pin_in = NCH'($urandom);
      ctr_out_in  = NCH'($urandom);
   endtask

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < NCH; i++) begin m_clk[i] = 0; m_gate[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset routing under two input patterns
      for (int k = 0; k < 2; k++) begin
         @(negedge clk); shake_inputs(); check_all("R1");
      end

      // R2 / R5 / R6: directed field decode, block 1 channel 2 = index 5
      write_sel(8'b00_1_10_110, 1'b1, 1'b0, 1'b0);   // clock code 6
      shake_inputs(); check_all("R2");
      chk("R5", int'(ch_clk_out[5]), int'(ctr_out_in[4]));
      write_sel(8'b00_0_00_110, 1'b1, 1'b0, 1'b0);   // ch0 takes last channel
      ctr_out_in = 6'b100000; #1;
      chk("R5", int'(ch_clk_out[0]), 1);
      write_sel(8'b00_0_01_001, 1'b0, 1'b1, 1'b0);   // gate pin on ch1
      gate_pin_in = 6'b000010; #1;
      chk("R6", int'(ch_gate_out[1]), 1);
      gate_pin_in = 6'b000000; #1;
      chk("R6", int'(ch_gate_out[1]), 0);

      // R3: channel field 3 ignored
      write_sel(8'b00_0_11_010, 1'b1, 1'b1, 1'b1);
      shake_inputs(); check_all("R3");

      // R7: wide code refused without enhanced mode
      write_sel(8'b01_1_00_011, 1'b1, 1'b0, 1'b0);
      shake_inputs(); check_all("R7");
      chk("R7", int'(ch_clk_out[3]), int'(ext_clk_in[3]));

      // R8: code 11 with enhanced mode, then R9 after mode drops
      write_sel(8'b01_1_00_011, 1'b1, 1'b0, 1'b1);
      begin
         int hi = 0;
         for (int c = 0; c < 50; c++) begin
            @(negedge clk); #1; if (ch_clk_out[3]) hi++;
         end
         chk("R8", hi, 50);
      end
      @(negedge clk); enh_mode = 1'b0; #1;
      chk("R9", int'(ch_clk_out[3]), 0);
      write_sel(8'b00_1_00_111, 1'b1, 1'b1, 1'b0);   // clock 7, gate 7
      ext_clk_in = '1; check_all("R9");

      // R10: both strobes share the byte; single strobe leaves the other
      write_sel(8'b00_1_01_010, 1'b1, 1'b1, 1'b0);
      shake_inputs(); check_all("R10");
      write_sel(8'b00_1_01_000, 1'b0, 1'b1, 1'b0);
      shake_inputs(); check_all("R10");

      // random mix
      for (int n = 0; n < 300; n++) begin
         int w = $urandom % 3;
         write_sel(8'($urandom), (w != 1), (w != 0), 1'($urandom));
         shake_inputs();
         check_all("R2 random");
      end

      // R4: five reference rates over one 20000-cycle window
      for (int i = 0; i < 5; i++)
         write_sel({2'b00, 1'(i / 3), 2'(i % 3), 3'(i + 1)}, 1'b1, 1'b0, 1'b0);
      begin
         int cnt [5];
         int exp_cnt [5] = '{10000, 1000, 100, 10, 1};
         for (int i = 0; i < 5; i++) cnt[i] = 0;
         for (int c = 0; c < 20000; c++) begin
            @(negedge clk); #1;
            for (int i = 0; i < 5; i++) if (ch_clk_out[i]) cnt[i]++;
         end
         for (int i = 0; i < 5; i++) chk("R4", cnt[i], exp_cnt[i]);
      end

      report();
   end

endmodule